// File: doc/BRIEF.md
# Kick-Updated Clock Ratio Controller

The block turns one source clock into eleven divided clock-enable streams. Each stream pulses high for one source cycle once every N source cycles. N comes from a 4-bit ratio code held in a field of one of two 32-bit control registers. The codes map to a non-linear set of divide values, and one of the codes is reserved. Two streams take their code from the same field, so they always run at the same ratio.

Software writes new codes through a single-cycle register port. Writes change only the shadow fields, and the shadow fields are also what the port reads back. The running dividers keep their old ratios until software sets the kick bit with a read-modify-write of register 1. The pending update then waits for the next frame boundary. A frame is the least common multiple of all legal divide values, which is 144 cycles. Every divider completes a whole period at that edge, so all of them take their new ratio together, and no period is cut short or stretched.

Each field has its own set of accepted codes. A write that carries a code the field does not accept leaves that field unchanged and sets a sticky error output. Other fields in the same write are still updated.

Top module: `kick_ratio_ctrl`

## Requirements
- R1: After reset, register 0 reads 0x0012_0453, register 1 reads 0x0260_7080, the kick bit reads 0 and `cfg_err_o` is 0. Every output runs at the divide value given by its default code.
- R2: Code values 0..11 select divide values 2, 3, 4, 6, 8, 12, 16, 18, 24, reserved, 36 and 48. Output k pulses for one cycle every N cycles, where N is the divide value of its active code.
- R3: A write to register 0 (`reg_sel_i`=0) or register 1 (`reg_sel_i`=1) updates the accepted shadow fields. The new value shows on `reg_rdata_o` in the next cycle, and the active ratios do not change until a kick.
- R4: A field written with code 9, or with any code from 12 to 15, keeps its previous value and sets `cfg_err_o`. Accepted fields in the same write still update.
- R5: The fields at register 0 bits 19:16 (output 1) and register 1 bits 27:24 (output 6) reject code 10. All other fields accept code 10.
- R6: Writing register 1 with bit 31 set makes bit 31 read 1 until the update has been applied, and then it clears by itself. Writing register 1 with bit 31 at 0 does not set it.
- R7: A pending update is applied at the edge that follows the cycle in which every output pulses together. The last period before the switch has the old length and the first period after it has the new length.
- R8: Outputs 2 and 3 both follow register 0 bits 11:8 and their enables are always identical.
- R9: Bits that lie outside every field read 0 whatever is written to them. These are register 0 bits 31:24 and 15:12, and register 1 bits 30:28, 11:8 and 3:0.
- R10: `cfg_err_o` stays 1 after a rejected write until reset, even if later writes are all accepted.

Field map, output index to register and bits: output 0 reg0[23:20]; output 1 reg0[19:16]; outputs 2 and 3 reg0[11:8]; output 4 reg0[7:4]; output 5 reg0[3:0]; output 6 reg1[27:24]; output 7 reg1[23:20]; output 8 reg1[19:16]; output 9 reg1[15:12]; output 10 reg1[7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_sel_i | input | 1 | Register select: 0 or 1, for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Shadow contents of the selected register, with the kick state in bit 31 of register 1 |
| ce_o | output | 11 | One-cycle clock-enable pulse per output |
| cfg_err_o | output | 1 | Sticky flag for rejected codes |

## Verification
The hardest case to reach from the ports is the switch-over edge. The kick can land anywhere in a 144-cycle frame, and the bench has to confirm that every output pulsed together in the last cycle before the kick bit cleared. It also has to confirm that the periods on both sides of that edge are whole periods. The kick scenario therefore sets the kick bit by read-modify-write and then watches one output on every falling edge. It records each gap under the old ratio until bit 31 reads 0, checks that all enables were high in the cycle before, and then counts the first new period. A second kick moves a different output from 16 to 36, so the switch is covered for two ratio pairs.

// File: rtl/kratio_pkg.sv
package kratio_pkg;

   localparam int CODE_W     = 4;
   localparam int NUM_CODES  = 12;
   localparam int RSVD_CODE  = 9;
   localparam int NUM_FIELDS = 10;
   localparam int NUM_OUTS   = 11;
   localparam int REG_W      = 32;
   localparam int KICK_BIT   = 31;
   localparam int MAX_DIV    = 48;
   localparam int CNT_W      = $clog2(MAX_DIV);

   typedef logic [CODE_W-1:0]    code_t;
   typedef logic [NUM_CODES-1:0] cmask_t;

   // register holding each field (0 or 1) and its lowest bit
   localparam int FLD_REG [NUM_FIELDS] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1};
   localparam int FLD_LSB [NUM_FIELDS] = '{20, 16, 8, 4, 0, 24, 20, 16, 12, 4};
   localparam int FLD_DEF [NUM_FIELDS] = '{1, 2, 4, 5, 3, 2, 6, 0, 7, 8};

   // field feeding each output; outputs 2 and 3 share a field
   localparam int OUT_FLD [NUM_OUTS] = '{0, 1, 2, 2, 3, 4, 5, 6, 7, 8, 9};
   localparam cmask_t OUT_MASK [NUM_OUTS] = '{
      12'hfff, 12'hbff, 12'hfff, 12'hfff, 12'hfff, 12'hfff,
      12'hbff, 12'hfff, 12'hfff, 12'hfff, 12'hfff};

   function automatic int code_div(input int c);
      case (c)
         0:       return 2;
         1:       return 3;
         2:       return 4;
         3:       return 6;
         4:       return 8;
         5:       return 12;
         6:       return 16;
         7:       return 18;
         8:       return 24;
         10:      return 36;
         11:      return 48;
         default: return 0;
      endcase
   endfunction

   function automatic int gcd(input int a, input int b);
      int x = a;
      int y = b;
      while (y != 0) begin
         int t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   // common boundary of all legal divide values
   function automatic int frame_len();
      int l = 1;
      for (int c = 0; c < NUM_CODES; c++) begin
         int d = code_div(c);
         if (d != 0) l = (l / gcd(l, d)) * d;
      end
      return l;
   endfunction

   function automatic cmask_t field_mask(input int f);
      cmask_t m = '1;
      for (int o = 0; o < NUM_OUTS; o++)
         if (OUT_FLD[o] == f) m &= OUT_MASK[o];
      m[RSVD_CODE] = 1'b0;
      return m;
   endfunction

   function automatic logic code_ok(input code_t c, input cmask_t m);
      cmask_t s;
      if (int'(c) >= NUM_CODES) return 1'b0;
      s = m >> c;
      return s[0];
   endfunction

endpackage

// File: rtl/kratio_frame.sv
module kratio_frame #(
   parameter int FRAME_LEN = 144,
   localparam int FW = $clog2(FRAME_LEN)
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic frame_end_o
);
   logic [FW-1:0] cnt_q;

   assign frame_end_o = (cnt_q == FW'(FRAME_LEN - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (frame_end_o) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/kratio_shadow.sv
module kratio_shadow
   import kratio_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic             sel_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             apply_i,
   output logic [REG_W-1:0] rdata_o,
   output code_t            fld_o [NUM_FIELDS],
   output logic             pend_o,
   output logic             err_o
);
   code_t fld_q [NUM_FIELDS];
   logic  pend_q, err_q;
   logic [REG_W-1:0] view0, view1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int f = 0; f < NUM_FIELDS; f++) fld_q[f] <= code_t'(FLD_DEF[f]);
         err_q <= 1'b0;
      end else if (we_i) begin
         for (int f = 0; f < NUM_FIELDS; f++) begin
            if ((FLD_REG[f] != 0) == sel_i) begin
               if (code_ok(wdata_i[FLD_LSB[f] +: CODE_W], field_mask(f)))
                  fld_q[f] <= wdata_i[FLD_LSB[f] +: CODE_W];
               else
                  err_q <= 1'b1;
            end
         end
      end
   end

   // a new kick request wins over the clear of an older one
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               pend_q <= 1'b0;
      else if (we_i && sel_i && wdata_i[KICK_BIT]) pend_q <= 1'b1;
      else if (apply_i)                          pend_q <= 1'b0;
   end

   always_comb begin
      view0 = '0;
      view1 = '0;
      for (int f = 0; f < NUM_FIELDS; f++) begin
         if (FLD_REG[f] == 0) view0[FLD_LSB[f] +: CODE_W] = fld_q[f];
         else                 view1[FLD_LSB[f] +: CODE_W] = fld_q[f];
      end
      view1[KICK_BIT] = pend_q;
   end

   assign rdata_o = sel_i ? view1 : view0;
   assign fld_o   = fld_q;
   assign pend_o  = pend_q;
   assign err_o   = err_q;
endmodule

// File: rtl/kratio_divider.sv
module kratio_divider
   import kratio_pkg::*;
#(
   parameter int RST_CODE = 0
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  frame_end_i,
   input  logic  apply_i,
   input  code_t code_i,
   output logic  ce_o
);
   code_t            act_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   always_comb last = CNT_W'(code_div(int'(act_q)) - 1);

   assign ce_o = (cnt_q == last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= code_t'(RST_CODE);
         cnt_q <= '0;
      end else begin
         if (apply_i) act_q <= code_i;
         if (frame_end_i || ce_o) cnt_q <= '0;
         else                     cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/kick_ratio_ctrl.sv
module kick_ratio_ctrl
   import kratio_pkg::*;
#(
   parameter int FRAME_LEN = kratio_pkg::frame_len()
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                reg_we_i,
   input  logic                reg_sel_i,
   input  logic [REG_W-1:0]    reg_wdata_i,
   output logic [REG_W-1:0]    reg_rdata_o,
   output logic [NUM_OUTS-1:0] ce_o,
   output logic                cfg_err_o
);
   logic  frame_end, kick_pend, apply;
   code_t fld [NUM_FIELDS];

   for (genvar c = 0; c < NUM_CODES; c++) begin : g_chk_div
      if (code_div(c) != 0 && (FRAME_LEN % code_div(c)) != 0) begin : g_bad
         $error("frame length is not a multiple of every divide value");
      end
   end
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_chk_fld
      if (FLD_LSB[f] + CODE_W > KICK_BIT) begin : g_bad_pos
         $error("ratio field overlaps the kick bit");
      end
      if (!code_ok(code_t'(FLD_DEF[f]), field_mask(f))) begin : g_bad_def
         $error("default code not accepted by its field");
      end
   end

   kratio_frame #(.FRAME_LEN(FRAME_LEN)) frame_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frame_end_o(frame_end)
   );

   assign apply = frame_end & kick_pend;

   kratio_shadow shadow_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (reg_we_i),
      .sel_i  (reg_sel_i),
      .wdata_i(reg_wdata_i),
      .apply_i(apply),
      .rdata_o(reg_rdata_o),
      .fld_o  (fld),
      .pend_o (kick_pend),
      .err_o  (cfg_err_o)
   );

   for (genvar o = 0; o < NUM_OUTS; o++) begin : g_div
      kratio_divider #(.RST_CODE(FLD_DEF[OUT_FLD[o]])) div_i (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .frame_end_i(frame_end),
         .apply_i    (apply),
         .code_i     (fld[OUT_FLD[o]]),
         .ce_o       (ce_o[o])
      );
   end
endmodule

// File: rtl/kick_ratio_ctrl_chk.sv
module kick_ratio_ctrl_chk
   import kratio_pkg::*;
(
   input logic                clk_i,
   input logic                rst_ni,
   input logic                reg_we_i,
   input logic [NUM_OUTS-1:0] ce_o,
   input logic                cfg_err_o,
   input logic                frame_end,
   input logic                kick_pend
);
   // R7: every divider ends a period at the frame boundary
   a_r7_all_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_end |-> (&ce_o));

   // R8: the two outputs on the shared field never differ
   a_r8_shared_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ce_o[2] == ce_o[3]);

   // R10: the error flag never falls while out of reset
   a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$fell(cfg_err_o));

   // R6: a pending kick clears only after a frame boundary
   a_r6_clear_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(kick_pend) |-> $past(frame_end));

   // R6: a kick becomes pending only through a register write
   a_r6_set_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(kick_pend) |-> $past(reg_we_i));

   // R2: the smallest divide value is 2, so pulses are never back to back
   for (genvar o = 0; o < NUM_OUTS; o++) begin : g_pulse
      a_r2_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ce_o[o] |=> !ce_o[o]);
   end
endmodule

bind kick_ratio_ctrl kick_ratio_ctrl_chk chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .reg_we_i (reg_we_i),
   .ce_o     (ce_o),
   .cfg_err_o(cfg_err_o),
   .frame_end(frame_end),
   .kick_pend(kick_pend)
);

// File: tb/kick_ratio_ctrl_tb_top.sv
module kick_ratio_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic        sel = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [10:0] ce;
   logic        err;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   kick_ratio_ctrl dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .reg_we_i   (we),
      .reg_sel_i  (sel),
      .reg_wdata_i(wdata),
      .reg_rdata_o(rdata),
      .ce_o       (ce),
      .cfg_err_o  (err)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input bit s, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input bit s, output logic [31:0] d);
      @(negedge clk);
      sel = s;
      #1 d = rdata;
   endtask

   task automatic period(input int k, input int exp, input string req);
      int n;
      @(negedge clk);
      while (!ce[k]) @(negedge clk);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!ce[k]);
      check(n == exp, req, n, exp);
   endtask

   // set the kick bit, follow output k through the switch
   task automatic kick_watch(input int k, input int old_n, input int new_n);
      logic [31:0] b;
      bit prev_all = 0, saw = 0, bad = 0, first = 1;
      int gap = 0, n;
      rd(1'b1, b);
      wr(1'b1, b | 32'h8000_0000);
      sel = 1'b1;
      forever begin
         #1;
         if (first) begin
            check(rdata[31] == 1'b1, "R6 kick reads 1 while pending", rdata[31], 1);
            first = 0;
         end
         if (!rdata[31]) break;
         gap++;
         if (ce[k]) begin
            if (saw && gap != old_n) bad = 1;
            saw = 1; gap = 0;
         end
         prev_all = &ce;
         @(negedge clk);
      end
      check(!bad, "R7 old periods whole before switch", bad, 0);
      check(prev_all, "R7 all outputs pulse at switch edge", prev_all, 1);
      n = 1;
      while (!ce[k]) begin
         @(negedge clk);
         n++;
      end
      check(n == new_n, "R7 first new period full length", n, new_n);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(1'b0, d); check(d == 32'h0012_0453, "R1 reg0 default", d, 32'h0012_0453);
      rd(1'b1, d); check(d == 32'h0260_7080, "R1 reg1 default, kick clear", d, 32'h0260_7080);
      check(err == 1'b0, "R1 error flag clear", err, 0);
      period(0, 3, "R1 R2 out0 code1");
      period(8, 2, "R1 R2 out8 code0");
      period(10, 24, "R1 R2 out10 code8");
      period(9, 18, "R1 R2 out9 code7");
   endtask

   task automatic t_shadow_hold;
      logic [31:0] d;
      wr(1'b0, 32'h0008_067A);
      rd(1'b0, d); check(d == 32'h0008_067A, "R3 shadow readback", d, 32'h0008_067A);
      check(err == 1'b0, "R3 valid write no error", err, 0);
      repeat (200) @(negedge clk);
      period(0, 3, "R3 out0 unchanged before kick");
      period(5, 6, "R3 out5 unchanged before kick");
   endtask

   task automatic t_kick;
      logic [31:0] d;
      kick_watch(5, 6, 36);
      rd(1'b1, d); check(d[31] == 1'b0, "R6 kick self-clears", d[31], 0);
      period(0, 2, "R2 out0 code0");
      period(1, 24, "R2 out1 code8");
      period(2, 16, "R8 out2 code6");
      period(3, 16, "R8 out3 code6");
      period(4, 18, "R2 out4 code7");
   endtask

   task automatic t_shared;
      bit same = 1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (ce[2] != ce[3]) same = 0;
      end
      check(same, "R8 shared outputs identical", same, 1);
   endtask

   task automatic t_reserved;
      logic [31:0] d;
      wr(1'b0, 32'h00B8_0679);
      rd(1'b0, d); check(d == 32'h00B8_067A, "R4 code9 kept, other field updated", d, 32'h00B8_067A);
      check(err == 1'b1, "R4 error set on code9", err, 1);
      wr(1'b0, 32'h00B8_067A);
      check(err == 1'b1, "R10 error stays after valid write", err, 1);
   endtask

   task automatic t_mask;
      logic [31:0] d;
      wr(1'b0, 32'h00BA_067A);
      rd(1'b0, d); check(d == 32'h00B8_067A, "R5 code10 rejected on reg0[19:16]", d, 32'h00B8_067A);
      wr(1'b1, 32'h0AA1_D080);
      rd(1'b1, d); check(d == 32'h02A1_7080, "R5 R4 reg1 mixed accept/reject", d, 32'h02A1_7080);
      kick_watch(7, 16, 36);
      period(8, 3, "R2 out8 code1");
      period(0, 48, "R2 out0 code11");
      period(6, 4, "R5 out6 kept code2");
   endtask

   task automatic t_nonfield;
      logic [31:0] d;
      wr(1'b0, 32'hFF00_F000 | 32'h00B8_067A);
      rd(1'b0, d); check(d == 32'h00B8_067A, "R9 reg0 gap bits read 0", d, 32'h00B8_067A);
      wr(1'b1, 32'h7000_0F0F | 32'h02A1_7080);
      rd(1'b1, d); check(d == 32'h02A1_7080, "R9 R6 reg1 gap bits 0, no kick", d, 32'h02A1_7080);
      repeat (3) @(negedge clk);
      #1 check(rdata[31] == 1'b0, "R6 write with bit31 clear sets no kick", rdata[31], 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_shadow_hold();
      t_kick();
      t_shared();
      t_reserved();
      t_mask();
      t_nonfield();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule